// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the sending half of an asynchronous serial port. A host places one data word in a holding register and then clears an empty flag to hand the word over. On the next baud tick the block copies the word into its frame shifter, raises the empty flag again, and starts driving the frame onto the serial line. The host can therefore queue the following word while the current frame is still on the line.

Each frame has a low start bit and 7 or 8 data bits, least significant bit first. An optional extra bit follows the data: even parity, odd parity, or a host-supplied multiprocessor bit. One or two high stop bits close the frame. The empty flag is examined at the end of the last stop bit. If a word is waiting, its start bit follows with no idle time. If no word is waiting, an end flag is raised and the line stays high.

Two interrupt request outputs report the empty flag and the end flag. Each is gated by its own enable input. A baud-tick input sets the bit rate, and every bit lasts exactly one tick interval.

Top module: `async_tx_buffered`

## Requirements
- R1: After reset the line is high, the empty flag is 1 and the end flag is 1.
- R2: When the empty flag is 0 at a baud tick and no frame is in progress, the held word is loaded on that tick. The empty flag returns to 1 in the next cycle, and the start bit (0) appears on the line.
- R3: Data bits follow the start bit least significant bit first. There are 8 of them when the short-length control is 0 and 7 (the top bit dropped) when it is 1.
- R4: With extra-bit mode 2'b01, one parity bit follows the data. With the odd control at 0, data plus parity holds an even number of ones; with it at 1, an odd number. Modes 2'b00 and 2'b11 send no extra bit.
- R5: With extra-bit mode 2'b10, the bit after the data equals the multiprocessor control input as it stood at the tick that loaded the frame.
- R6: A frame ends with one stop bit at 1, or two when the two-stop control is 1.
- R7: The line changes only in the cycle after a baud tick, so each bit lasts exactly one tick interval.
- R8: If the empty flag is 0 when the last stop bit ends, the next start bit follows on the very next bit period with no idle bit.
- R9: If the empty flag is 1 when the last stop bit ends, the end flag becomes 1 and the line stays at 1 until a later load.
- R10: A data write while the empty flag is 0 does not change the held word, and a clear request while the empty flag is 0 has no effect.
- R11: A clear request that takes effect also clears the end flag.
- R12: The empty interrupt request equals the empty flag ANDed with its enable, and the end interrupt request equals the end flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Data word to hold |
| empty_clr | input | 1 | Host request to clear the empty flag (hand over the word) |
| cfg_short | input | 1 | 1 = send DATA_W-1 data bits |
| cfg_extra | input | 2 | Extra bit: 00 none, 01 parity, 10 multiprocessor, 11 none |
| cfg_odd | input | 1 | 1 = odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_mpb | input | 1 | Multiprocessor bit value |
| ie_empty | input | 1 | Enable for the empty interrupt request |
| ie_end | input | 1 | Enable for the end interrupt request |
| txd | output | 1 | Serial line, idle high |
| empty_flag | output | 1 | Holding register free |
| end_flag | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Empty interrupt request |
| irq_end | output | 1 | End interrupt request |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that the host hands over a word only by writing while the empty flag is 1 and then clearing it. The no-gap and load checks also rely on a new word arriving well before the stop bit of the frame in flight ends.

The bench drives the tick from a free-running divide-by-eight counter. It changes configuration only while the line is idle. Each next word is queued right after the empty flag returns to 1, so this timing is always met. The ignored-write case is started just after a tick, so the stray write and the stray clear both land before the next load.

// File: rtl/async_tx_pkg.sv
// Package: shared types for the buffered asynchronous transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package async_tx_pkg;

    // Selects what follows the data bits in a frame.
    typedef enum logic [1:0] {
        EXTRA_NONE   = 2'b00,
        EXTRA_PARITY = 2'b01,
        EXTRA_MPB    = 2'b10,
        EXTRA_RSVD   = 2'b11
    } extra_e;

    // Frame format controls as seen by the frame builder.
    typedef struct packed {
        logic   short_len;
        extra_e extra;
        logic   odd;
        logic   two_stop;
        logic   mpb;
    } frame_cfg_t;

endpackage

// File: rtl/atx_holding.sv
// Module: holding register with empty and end flags.
// Does: accepts a host word while empty, lets the host hand it over by
//       clearing the empty flag, and re-sets the flag when the shifter loads it.
// Assumes: load_ack is only asserted while empty_q is 0.
module atx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              empty_clr,
    input  logic              load_ack,
    input  logic              frame_done,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q,
    output logic              end_q
);

    logic clr_take;

    // A clear only counts while the register is free.
    assign clr_take = empty_clr && empty_q;

    // Capture host data; writes while a word is pending are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_wr && empty_q) begin
            hold_q <= hold_wdata;
        end
    end

    // Empty flag: set on load, cleared by an accepted host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (load_ack) begin
            empty_q <= 1'b1;
        end else if (clr_take) begin
            empty_q <= 1'b0;
        end
    end

    // End flag: set when the line goes idle, cleared with the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b1;
        end else if (clr_take) begin
            end_q <= 1'b0;
        end else if (frame_done) begin
            end_q <= 1'b1;
        end
    end

    a_r2_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> empty_q);

    a_r10_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_q |=> $stable(hold_q));

    a_r11_end_falls_with_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_q) |-> $fell(empty_q));

    a_r9_end_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_q) |-> $past(frame_done));

endmodule

// File: rtl/atx_frame_builder.sv
// Module: combinational frame assembly.
// Does: lays out start, data, optional extra bit and stop bits as a vector
//       sent from bit 0 upward, and reports the frame length.
// Assumes: DATA_W >= 2; unused upper bits are filled with 1 (mark).
module atx_frame_builder
    import async_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  frame_cfg_t         cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   frame_len
);

    int          nbits;
    logic        has_extra;
    logic        extra_bit;
    logic [DATA_W-1:0] used_mask;

    // Number of data bits and the mask of those sent.
    always_comb begin
        nbits     = cfg.short_len ? DATA_W - 1 : DATA_W;
        used_mask = cfg.short_len ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    end

    // Choose the bit that follows the data, if any.
    always_comb begin
        has_extra = (cfg.extra == EXTRA_PARITY) || (cfg.extra == EXTRA_MPB);
        if (cfg.extra == EXTRA_MPB) begin
            extra_bit = cfg.mpb;
        end else begin
            extra_bit = (^(data & used_mask)) ^ cfg.odd;
        end
    end

    // Assemble the frame vector and its length.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                frame[1 + i] = data[i];
            end
        end
        if (has_extra) begin
            frame[1 + nbits] = extra_bit;
        end
        frame_len = LEN_W'(1 + nbits + (has_extra ? 1 : 0) + (cfg.two_stop ? 2 : 1));
    end

endmodule

// File: rtl/atx_shifter.sv
// Module: frame shifter and line driver.
// Does: on baud ticks loads a frame when one is pending and the line is
//       free or on its last stop bit, then shifts it out one bit per tick.
// Assumes: baud_tick is a one-cycle pulse; frame_len >= 2.
module atx_shifter #(
    parameter int FRAME_W = 12,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               pending,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   frame_len,
    output logic               load_ack,
    output logic               frame_done,
    output logic               txd
);

    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   rem_q;
    logic               busy_q;
    logic               txd_q;
    logic               last_bit;

    // The current bit is the final stop bit of a frame.
    assign last_bit   = busy_q && (rem_q == '0);
    assign load_ack   = baud_tick && pending && (!busy_q || last_bit);
    assign frame_done = baud_tick && last_bit && !pending;
    assign txd        = txd_q;

    // Advance the line one bit per tick, reloading at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            rem_q  <= '0;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
        end else if (baud_tick) begin
            if (load_ack) begin
                txd_q  <= frame[0];
                sh_q   <= {1'b1, frame[FRAME_W-1:1]};
                rem_q  <= frame_len - LEN_W'(1);
                busy_q <= 1'b1;
            end else if (busy_q && !last_bit) begin
                txd_q  <= sh_q[0];
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                rem_q  <= rem_q - LEN_W'(1);
            end else if (busy_q) begin
                busy_q <= 1'b0;
                txd_q  <= 1'b1;
            end
        end
    end

    a_r7_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd_q));

    a_r9_idle_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> txd_q);

    a_r2_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> (busy_q && !txd_q));

    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && last_bit && pending) |=> (busy_q && !txd_q));

endmodule

// File: rtl/async_tx_buffered.sv
// Module: top of the buffered asynchronous serial transmitter.
// Does: ties the holding register, frame builder and shifter together and
//       gates the two interrupt requests with their enables.
// Assumes: the host writes a word while empty_flag is 1, then pulses empty_clr.
module async_tx_buffered
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              empty_clr,
    input  logic              cfg_short,
    input  logic [1:0]        cfg_extra,
    input  logic              cfg_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_mpb,
    input  logic              ie_empty,
    input  logic              ie_end,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              irq_empty,
    output logic              irq_end
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  hold_q;
    logic               empty_q;
    logic               end_q;
    logic               load_ack;
    logic               frame_done;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;
    frame_cfg_t         cfg;

    // Gather the live format controls; they are frozen by the load.
    always_comb begin
        cfg.short_len = cfg_short;
        cfg.extra     = extra_e'(cfg_extra);
        cfg.odd       = cfg_odd;
        cfg.two_stop  = cfg_two_stop;
        cfg.mpb       = cfg_mpb;
    end

    atx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_wr    (hold_wr),
        .hold_wdata (hold_wdata),
        .empty_clr  (empty_clr),
        .load_ack   (load_ack),
        .frame_done (frame_done),
        .hold_q     (hold_q),
        .empty_q    (empty_q),
        .end_q      (end_q)
    );

    atx_frame_builder #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
        .data      (hold_q),
        .cfg       (cfg),
        .frame     (frame),
        .frame_len (frame_len)
    );

    atx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .pending    (!empty_q),
        .frame      (frame),
        .frame_len  (frame_len),
        .load_ack   (load_ack),
        .frame_done (frame_done),
        .txd        (txd)
    );

    // Flags and gated interrupt requests to the host.
    assign empty_flag = empty_q;
    assign end_flag   = end_q;
    assign irq_empty  = empty_q && ie_empty;
    assign irq_end    = end_q && ie_end;

endmodule

// File: tb/async_tx_buffered_bench.sv
module async_tx_buffered_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    typedef int bitq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_wr = 1'b0;
    logic [DW-1:0] hold_wdata = '0;
    logic empty_clr = 1'b0;
    logic cfg_short = 1'b0;
    logic [1:0] cfg_extra = 2'b00;
    logic cfg_odd = 1'b0;
    logic cfg_two_stop = 1'b0;
    logic cfg_mpb = 1'b0;
    logic ie_empty = 1'b0;
    logic ie_end = 1'b0;
    logic txd, empty_flag, end_flag, irq_empty, irq_end;
    logic baud_tick;
    logic [2:0] bcnt = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit cap_on = 0;
    int cap[$];

    int m_txd, m_empty, m_end, m_busy, m_hold;
    int m_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_tx_buffered #(.DATA_W(DW)) u_async_tx_buffered (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .hold_wr(hold_wr), .hold_wdata(hold_wdata), .empty_clr(empty_clr),
        .cfg_short(cfg_short), .cfg_extra(cfg_extra), .cfg_odd(cfg_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_mpb(cfg_mpb),
        .ie_empty(ie_empty), .ie_end(ie_end),
        .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    // Baud tick every eight clocks.
    always @(posedge clk) bcnt <= bcnt + 3'd1;
    assign baud_tick = (bcnt == 3'd7);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected frame bits, in line order.
    function automatic bitq_t exp_frame(input int data, input bit sh, input int ext,
                                        input bit odd, input bit two, input bit mpb);
        bitq_t q;
        int n;
        int par;
        q.push_back(0);
        n = sh ? DW - 1 : DW;
        par = 0;
        for (int i = 0; i < n; i++) begin
            q.push_back((data >> i) & 1);
            par ^= (data >> i) & 1;
        end
        if (ext == 1) q.push_back(par ^ int'(odd));
        else if (ext == 2) q.push_back(int'(mpb));
        q.push_back(1);
        if (two) q.push_back(1);
        return q;
    endfunction

    // Behavioural reference, advanced on every clock.
    always @(posedge clk) begin : mdl
        int oe;
        bit ack;
        bit done;
        bitq_t f;
        ack = 0;
        done = 0;
        if (!rst_n) begin
            m_txd = 1; m_empty = 1; m_end = 1; m_busy = 0; m_hold = 0;
            m_q.delete();
        end else begin
            oe = m_empty;
            if (baud_tick) begin
                if (m_busy != 0 && m_q.size() > 0) begin
                    m_txd = m_q.pop_front();
                end else if (oe == 0) begin
                    f = exp_frame(m_hold, cfg_short, int'(cfg_extra), cfg_odd, cfg_two_stop, cfg_mpb);
                    m_txd = f.pop_front();
                    m_q = f;
                    m_busy = 1;
                    ack = 1;
                end else if (m_busy != 0) begin
                    m_busy = 0;
                    m_txd = 1;
                    done = 1;
                end
            end
            if (hold_wr && oe != 0) m_hold = int'(hold_wdata);
            if (ack) m_empty = 1;
            else if (empty_clr && oe != 0) m_empty = 0;
            if (empty_clr && oe != 0) m_end = 0;
            else if (done) m_end = 1;
        end
    end

    // Compare against the reference away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(txd) == m_txd, "R7 line", int'(txd), m_txd);
            chk(int'(empty_flag) == m_empty, "R2 empty", int'(empty_flag), m_empty);
            chk(int'(end_flag) == m_end, "R9 end", int'(end_flag), m_end);
            chk(irq_empty == (m_empty != 0 && ie_empty), "R12 irq_empty", int'(irq_empty), int'(m_empty != 0 && ie_empty));
            chk(irq_end == (m_end != 0 && ie_end), "R12 irq_end", int'(irq_end), int'(m_end != 0 && ie_end));
        end
        if (cap_on && bcnt == 3'd3) cap.push_back(int'(txd));
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic put_word(input int w);
        @(negedge clk); hold_wr = 1'b1; hold_wdata = DW'(w);
        @(negedge clk); hold_wr = 1'b0; empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0;
    endtask

    // Check captured line samples against an expected stream then mark.
    task automatic check_stream(input bitq_t exp, input string req);
        int mism;
        while (cap.size() > 0 && cap[0] == 1) void'(cap.pop_front());
        mism = 0;
        for (int i = 0; i < exp.size(); i++) begin
            if (i >= cap.size() || cap[i] != exp[i]) mism++;
        end
        chk(mism == 0, req, mism, 0);
        chk(cap.size() > exp.size() && cap[exp.size()] == 1, "R9 mark after stream",
            (cap.size() > exp.size()) ? cap[exp.size()] : -1, 1);
    endtask

    task automatic send_pair(input int a, input int b, input string req);
        bitq_t e;
        bitq_t e2;
        cap.delete(); cap_on = 1;
        put_word(a);
        chk(end_flag == 1'b0, "R11 end cleared", int'(end_flag), 0);
        while (!empty_flag) @(negedge clk);
        put_word(b);
        while (!(end_flag && empty_flag)) @(negedge clk);
        repeat (24) @(negedge clk);
        cap_on = 0;
        e = exp_frame(a, cfg_short, int'(cfg_extra), cfg_odd, cfg_two_stop, cfg_mpb);
        e2 = exp_frame(b, cfg_short, int'(cfg_extra), cfg_odd, cfg_two_stop, cfg_mpb);
        foreach (e2[i]) e.push_back(e2[i]);
        check_stream(e, req);
    endtask

    initial begin
        bitq_t e;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(empty_flag == 1'b1, "R1 empty", int'(empty_flag), 1);
        chk(end_flag == 1'b1, "R1 end", int'(end_flag), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 gating with enables off and on
        chk(irq_empty == 1'b0 && irq_end == 1'b0, "R12 gated off", int'({irq_empty, irq_end}), 0);
        ie_empty = 1'b1; ie_end = 1'b1;
        @(negedge clk);
        chk(irq_empty == 1'b1 && irq_end == 1'b1, "R12 gated on", int'({irq_empty, irq_end}), 3);

        // Every format combination, two frames back to back (R3 R4 R5 R6 R8).
        for (int c = 0; c < 32; c++) begin
            cfg_short    = c[0];
            cfg_extra    = c[2:1];
            cfg_odd      = c[3];
            cfg_two_stop = c[4];
            cfg_mpb      = ~c[0] ^ c[3];
            ie_empty     = c[1];
            ie_end       = c[2];
            if (c[2:1] == 2'b01) send_pair(8'hA5 ^ c, 8'h3C + c, "R4 parity frames");
            else if (c[2:1] == 2'b10) send_pair(8'h81 + c, 8'hF0 ^ c, "R5 mpb frames");
            else if (c[4]) send_pair(8'hC3 ^ c, 8'h17 + c, "R6 two-stop frames");
            else send_pair(8'h96 - c, 8'hFF - c, "R8 back-to-back R3 data");
        end

        // R10: stray write and clear while a word is pending are ignored.
        cfg_short = 1'b0; cfg_extra = 2'b01; cfg_odd = 1'b0; cfg_two_stop = 1'b0;
        while (bcnt != 3'd0) @(negedge clk);
        cap.delete(); cap_on = 1;
        hold_wr = 1'b1; hold_wdata = 8'h5A;
        @(negedge clk); hold_wr = 1'b0; empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0; hold_wr = 1'b1; hold_wdata = 8'h00;
        @(negedge clk); hold_wr = 1'b0; empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0;
        chk(empty_flag == 1'b0, "R10 clear while pending", int'(empty_flag), 0);
        while (!(end_flag && empty_flag)) @(negedge clk);
        repeat (24) @(negedge clk);
        cap_on = 0;
        e = exp_frame(8'h5A, 1'b0, 1, 1'b0, 1'b0, 1'b0);
        check_stream(e, "R10 stray write ignored");
        chk(txd == 1'b1 && end_flag == 1'b1, "R9 idle after last frame", int'({txd, end_flag}), 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule